// File: doc/BRIEF.md
# Supply-Supervised Power-Mode Sequencer

This block decides when a metering peripheral may run. It watches a digital supply-good flag, two active-low mode-select pins and an active-low hardware reset pin. It reports one of four states: inactive, sleep, transitioning or normal. When the peripheral's registers must return to their defaults, it raises a one-cycle load pulse. All intervals are derived from the clock frequency parameter, so the same source serves any clock rate.

After the supply becomes good, the block waits a fixed power-on hold time, then always enters sleep. Software leaves sleep by driving the pin pattern that requests normal mode. The block then spends a fixed transition time counting, and enters normal mode with a done pulse and a defaults load. The hardware reset pin is honoured only in normal mode, and only for a complete low pulse of at least the minimum width. Loss of supply returns the block to inactive on the next clock edge from any state.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, `state` reads 0 (inactive), and `xfer_done` and `defaults_load` read 0.
- R2: While `supply_ok` is low, `state` stays 0 whatever the mode and reset pins do.
- R3: `state` leaves 0 on exactly the HOLD_CYC-th rising edge that samples `supply_ok` high, where HOLD_CYC = CLK_HZ*HOLD_MS/1000. A low sample of `supply_ok` before that edge restarts the count.
- R4: On leaving inactive, the block always enters sleep (`state` = 1).
- R5: The pins `mode1_n`=0 and `mode0_n`=1 request normal mode. In sleep, this pattern moves `state` to 2 (transitioning) on the third edge after the pins change. Any other pattern leaves the block in sleep.
- R6: The transitioning state lasts XFER_CYC = CLK_HZ*XFER_MS/1000 edges. The block then enters normal mode (`state` = 3). On the edge where it enters normal mode, `xfer_done` and `defaults_load` are both high for exactly one cycle.
- R7: If the pins stop showing the normal-request pattern while `state` is 2 or 3, `state` returns to 1 on the third edge after the change, and `xfer_done` is not raised.
- R8: In normal mode, a falling edge on `hw_rst_n` followed by a low time of L >= RST_CYC cycles arms a reset, where RST_CYC = CLK_HZ*RST_US/1000000. When the pin returns high, `defaults_load` pulses for one cycle on the (L+3)-th edge counted from the first edge that samples the pin low. `state` stays 3 throughout.
- R9: In normal mode, a low pulse on `hw_rst_n` shorter than RST_CYC cycles produces no `defaults_load` pulse.
- R10: A low level on `hw_rst_n` in any state other than normal has no effect. This includes a low level that began before normal mode was entered and ends within normal mode: its release produces no `defaults_load` pulse.
- R11: A low sample of `supply_ok` in any state sets `state` to 0 on that same edge. No load pulse follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| supply_ok | input | 1 | Supply-good flag from the external comparator, synchronous to clk |
| mode0_n | input | 1 | Mode-select pin 0, active low, pulled up |
| mode1_n | input | 1 | Mode-select pin 1, active low, pulled up; low requests normal mode |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| state | output | 2 | 0 inactive, 1 sleep, 2 transitioning, 3 normal |
| xfer_done | output | 1 | One-cycle pulse on completion of the sleep-to-normal transition |
| defaults_load | output | 1 | One-cycle pulse that restores all registers to their defaults |

## Verification
A change on `supply_ok` is seen on the next edge, because it enters the state register directly. A pin change reaches `state` on the third edge, after the two synchroniser stages and the state register. A qualified reset release reaches `defaults_load` on edge L+3, because the edge-detect flop adds one stage. The bench drives inputs on falling edges and counts rising edges to those exact offsets before it samples. It checks the cycle just before each expected change as well as the cycle of the change, so an early or late result is caught. Load and done pulses are also tallied on every rising edge, so a stray pulse is caught even between the sampled points.

// File: rtl/pms_pkg.sv
package pms_pkg;

   typedef enum logic [1:0] {
      PM_OFF   = 2'd0,
      PM_SLEEP = 2'd1,
      PM_XFER  = 2'd2,
      PM_RUN   = 2'd3
   } pm_state_t;

   // number of clock cycles in (amount / per_sec) seconds at hz
   function automatic longint span_cycles(longint hz, longint amount, longint per_sec);
      return (hz * amount) / per_sec;
   endfunction

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
   parameter int WIDTH     = 3,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pms_sync needs at least two stages");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pipe[s] <= {WIDTH{RESET_VAL}};
         else if (s == 0)
            pipe[s] <= d;
         else
            pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/pms_rst_qual.sv
module pms_rst_qual #(
   parameter int MIN_LOW = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pin_s,
   output logic fire
);

   localparam int CW = $clog2(MIN_LOW + 1);
   localparam logic [CW-1:0] LOW_LIM = CW'(MIN_LOW);

   if (MIN_LOW < 1) begin : g_bad_min
      $error("pms_rst_qual: minimum low time must be at least one cycle");
   end

   logic          pin_d;
   logic          armed;
   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_d   <= 1'b1;
         armed   <= 1'b0;
         low_cnt <= '0;
         fire    <= 1'b0;
      end else begin
         pin_d <= pin_s;
         fire  <= 1'b0;
         if (!enable) begin
            armed   <= 1'b0;
            low_cnt <= '0;
         end else if (pin_d && !pin_s) begin
            armed   <= 1'b1;
            low_cnt <= CW'(1);
         end else if (armed && !pin_s) begin
            if (low_cnt != LOW_LIM)
               low_cnt <= low_cnt + 1'b1;
         end else if (armed && pin_s) begin
            armed   <= 1'b0;
            low_cnt <= '0;
            fire    <= (low_cnt >= LOW_LIM);
         end
      end
   end

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
   import pms_pkg::*;
#(
   parameter longint HOLD_CYC = 1300000,
   parameter longint XFER_CYC = 2000000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      supply_ok,
   input  logic      req_run,
   output pm_state_t state,
   output logic      done,
   output logic      stay_run
);

   localparam longint CNT_MAX = (HOLD_CYC > XFER_CYC) ? HOLD_CYC : XFER_CYC;
   localparam int     CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] XFER_LAST = CW'(XFER_CYC - 1);

   if (HOLD_CYC < 1 || XFER_CYC < 1) begin : g_bad_span
      $error("pms_fsm: hold and transition spans must be at least one cycle");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PM_OFF;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!supply_ok) begin
            state <= PM_OFF;
            cnt   <= '0;
         end else begin
            case (state)
               PM_OFF: begin
                  if (cnt == HOLD_LAST) begin
                     state <= PM_SLEEP;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PM_SLEEP: begin
                  if (req_run) begin
                     state <= PM_XFER;
                     cnt   <= '0;
                  end
               end
               PM_XFER: begin
                  if (!req_run) begin
                     state <= PM_SLEEP;
                     cnt   <= '0;
                  end else if (cnt == XFER_LAST) begin
                     state <= PM_RUN;
                     cnt   <= '0;
                     done  <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  if (!req_run)
                     state <= PM_SLEEP;
               end
            endcase
         end
      end
   end

   assign stay_run = supply_ok && req_run && (state == PM_RUN);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter longint CLK_HZ      = 50000000,
   parameter int     HOLD_MS     = 26,
   parameter int     XFER_MS     = 40,
   parameter int     RST_US      = 10,
   parameter int     SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       mode0_n,
   input  logic       mode1_n,
   input  logic       hw_rst_n,
   output logic [1:0] state,
   output logic       xfer_done,
   output logic       defaults_load
);

   localparam longint HOLD_CYC = span_cycles(CLK_HZ, HOLD_MS, 1000);
   localparam longint XFER_CYC = span_cycles(CLK_HZ, XFER_MS, 1000);
   localparam int     RST_CYC  = int'(span_cycles(CLK_HZ, RST_US, 1000000));

   if (RST_CYC < 2) begin : g_bad_clk
      $error("pwr_mode_seq: clock too slow to time the reset pulse");
   end

   logic [2:0] pins_s;
   logic       req_run;
   logic       stay_run;
   logic       fsm_done;
   logic       rst_fire;
   pm_state_t  st;

   pms_sync #(
      .WIDTH     (3),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hw_rst_n, mode1_n, mode0_n}),
      .q     (pins_s)
   );

   assign req_run = !pins_s[1] && pins_s[0];

   pms_fsm #(
      .HOLD_CYC (HOLD_CYC),
      .XFER_CYC (XFER_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .req_run   (req_run),
      .state     (st),
      .done      (fsm_done),
      .stay_run  (stay_run)
   );

   pms_rst_qual #(
      .MIN_LOW (RST_CYC)
   ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (stay_run),
      .pin_s  (pins_s[2]),
      .fire   (rst_fire)
   );

   assign state         = st;
   assign xfer_done     = fsm_done;
   assign defaults_load = fsm_done | rst_fire;

endmodule

// File: rtl/pms_chk.sv
module pms_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic [1:0] state,
   input logic       xfer_done,
   input logic       defaults_load
);

   AST_BROWNOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> state == 2'd0);                                        // R11

   AST_WAKE_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      state == 2'd0 |=> (state == 2'd0 || state == 2'd1));                  // R4

   AST_RUN_VIA_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      state == 2'd1 |=> state != 2'd3);                                     // R6

   AST_DONE_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (state == 2'd3 && $past(state) == 2'd2));               // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);                                            // R6

   AST_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      defaults_load |-> state == 2'd3);                                     // R10

   AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      defaults_load |=> !defaults_load);                                    // R8

endmodule

bind pwr_mode_seq pms_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .supply_ok     (supply_ok),
   .state         (state),
   .xfer_done     (xfer_done),
   .defaults_load (defaults_load)
);

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;

   localparam longint CLK_HZ = 500000;
   localparam int HOLD = 13000;   // 26 ms at CLK_HZ
   localparam int XFER = 20000;   // 40 ms at CLK_HZ
   localparam int RSTW = 5;       // 10 us at CLK_HZ
   localparam int NV   = 7;
   localparam int VLEN [NV] = '{1, 2, 4, 5, 6, 9, 30};
   localparam int VEXP [NV] = '{0, 0, 0, 1, 1, 1, 1};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       supply_ok;
   logic       mode0_n;
   logic       mode1_n;
   logic       hw_rst_n;
   logic [1:0] st;
   logic       xfer_done;
   logic       defaults_load;

   int n_chk = 0;
   int n_bad = 0;
   int load_cnt = 0;
   int done_cnt = 0;

   always #10 clk = ~clk;

   pwr_mode_seq #(.CLK_HZ(CLK_HZ)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_ok     (supply_ok),
      .mode0_n       (mode0_n),
      .mode1_n       (mode1_n),
      .hw_rst_n      (hw_rst_n),
      .state         (st),
      .xfer_done     (xfer_done),
      .defaults_load (defaults_load)
   );

   always @(posedge clk) begin
      if (defaults_load) load_cnt++;
      if (xfer_done) done_cnt++;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int d0;
      int c0;
      rst_n = 1'b0; supply_ok = 1'b0; mode0_n = 1'b1; mode1_n = 1'b1; hw_rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 state in reset", int'(st), 0);
      check("R1 load in reset", int'(defaults_load), 0);
      check("R1 done in reset", int'(xfer_done), 0);
      rst_n = 1'b1;

      // R2: supply low, pins wiggled
      mode1_n = 1'b0; hw_rst_n = 1'b0;
      wait_edges(20);
      check("R2 inactive while supply low", int'(st), 0);
      mode1_n = 1'b1; hw_rst_n = 1'b1;
      wait_edges(4);

      // R3: hold interrupted then restarted
      supply_ok = 1'b1;
      wait_edges(HOLD - 100);
      check("R3 still inactive mid-hold", int'(st), 0);
      supply_ok = 1'b0;
      wait_edges(1);
      check("R3 dropout during hold", int'(st), 0);
      supply_ok = 1'b1;
      wait_edges(HOLD - 1);
      check("R3 inactive one edge before hold ends", int'(st), 0);
      wait_edges(1);
      check("R4 sleep after hold", int'(st), 1);

      // R5: non-request patterns keep sleep
      mode0_n = 1'b0; mode1_n = 1'b0;
      wait_edges(10);
      check("R5 both pins low stays sleep", int'(st), 1);
      mode0_n = 1'b0; mode1_n = 1'b1;
      wait_edges(10);
      check("R5 mode0 low only stays sleep", int'(st), 1);
      mode0_n = 1'b1; mode1_n = 1'b0;
      wait_edges(2);
      check("R5 sleep before sync delay", int'(st), 1);
      wait_edges(1);
      check("R5 transition on third edge", int'(st), 2);

      // R10: reset pin pulse during transition ignored
      d0 = load_cnt;
      hw_rst_n = 1'b0;
      wait_edges(10);
      hw_rst_n = 1'b1;
      wait_edges(10);
      check("R10 no load from pulse in transition", load_cnt - d0, 0);
      wait_edges(XFER - 21);
      check("R6 transition one edge before end", int'(st), 2);
      wait_edges(1);
      check("R6 normal entered", int'(st), 3);
      check("R6 done pulse at entry", int'(xfer_done), 1);
      check("R6 load pulse at entry", int'(defaults_load), 1);
      wait_edges(1);
      check("R6 done single cycle", int'(xfer_done), 0);
      check("R6 load single cycle", int'(defaults_load), 0);
      wait_edges(4);

      // R8 / R9: reset pulse widths from the vector table
      for (int i = 0; i < NV; i++) begin
         string tg;
         tg = (VEXP[i] != 0) ? "R8" : "R9";
         d0 = load_cnt;
         hw_rst_n = 1'b0;
         wait_edges(VLEN[i]);
         hw_rst_n = 1'b1;
         wait_edges(2);
         check($sformatf("%s len=%0d load early", tg, VLEN[i]), int'(defaults_load), 0);
         wait_edges(1);
         check($sformatf("%s len=%0d load at release", tg, VLEN[i]), int'(defaults_load), VEXP[i]);
         wait_edges(1);
         check($sformatf("%s len=%0d load cleared", tg, VLEN[i]), int'(defaults_load), 0);
         check($sformatf("%s len=%0d stays normal", tg, VLEN[i]), int'(st), 3);
         wait_edges(3);
         check($sformatf("%s len=%0d load count", tg, VLEN[i]), load_cnt - d0, VEXP[i]);
      end

      // R7: leave normal pattern
      mode1_n = 1'b1;
      wait_edges(2);
      check("R7 normal before sync delay", int'(st), 3);
      wait_edges(1);
      check("R7 back to sleep", int'(st), 1);

      // R7: abort during transition, with reset pin held low from sleep
      hw_rst_n = 1'b0;
      c0 = done_cnt;
      mode1_n = 1'b0;
      wait_edges(3);
      check("R5 transition again", int'(st), 2);
      wait_edges(100);
      mode1_n = 1'b1;
      wait_edges(3);
      check("R7 abort to sleep", int'(st), 1);
      wait_edges(2);
      check("R7 no done on abort", done_cnt - c0, 0);

      // R10: low level spanning normal entry
      d0 = load_cnt;
      mode1_n = 1'b0;
      wait_edges(3 + XFER);
      check("R6 normal after full transition", int'(st), 3);
      wait_edges(20);
      hw_rst_n = 1'b1;
      wait_edges(10);
      check("R10 pre-entry low gives only entry load", load_cnt - d0, 1);

      // R11: brown-out from normal
      d0 = load_cnt;
      supply_ok = 1'b0;
      wait_edges(1);
      check("R11 inactive after brown-out", int'(st), 0);
      wait_edges(5);
      check("R11 no load from brown-out", load_cnt - d0, 0);
      check("R11 stays inactive", int'(st), 0);

      finish_run();
   end

endmodule